// File: doc/BRIEF.md
# Cycle-Countdown IRQ Timer

This block is a 16-bit down-counter that raises an interrupt request after a programmed number of CPU bus cycles. The CPU writes to it over an 8-bit data bus. Each write is recognised by decoding the address under a mask. Software loads the live count as two bytes through one register, high byte first. It starts or pauses counting through a control register. It clears a pending interrupt by writing to a separate acknowledge address. The count moves once per cycle of the `cpu_tick` strobe. When it passes below zero it wraps to all ones, stops itself and holds the IRQ line low until the interrupt is acknowledged.

There are two state machines. The byte toggle has the states `TGL_HI` and `TGL_LO`:
- A load write in `TGL_HI` moves it to `TGL_LO`.
- A load write in `TGL_LO` moves it back to `TGL_HI`.
- A control write forces it to `TGL_HI` from either state.

The run machine has the states `RUN_PAUSED` and `RUN_ACTIVE`:
- A control write with the enable bit set moves it to `RUN_ACTIVE`.
- A control write with the enable bit clear moves it to `RUN_PAUSED`.
- An underflow moves it from `RUN_ACTIVE` to `RUN_PAUSED`.

Top module: `cyc_irq_timer`

## Requirements
- R1: A write is decoded under address mask 0xF800. (addr & 0xF800) == 0xC800 selects the load register, so 0xCFFF is a mirror of it. (addr & 0xF800) == 0xD800 selects the control register. A write to 0xE800 leaves the count and the IRQ unchanged.
- R2: The first load write sets count bits 15:8. The second sets bits 7:0. After the second write the toggle is back on the high byte.
- R3: A load write changes the live count at the next clock edge, with no reload copy. In a cycle where a decrement would also happen, the load wins and no decrement is applied.
- R4: Any control write returns the toggle to the high byte, whatever data is written.
- R5: Control data bit 4 set to 1 enables counting; set to 0 it pauses counting. While paused, the count holds even with `cpu_tick` high.
- R6: While enabled, the count drops by exactly one on each clock edge where `cpu_tick` is high. It is unchanged on edges where `cpu_tick` is low.
- R7: While enabled, a tick at count 0x0000 makes the count 0xFFFF. The same edge drives `irq_n` low and pauses the counter, so later ticks leave 0xFFFF in place.
- R8: A control write does not release a pending IRQ.
- R9: A write with (addr & 0x8800) == 0x8000 releases the IRQ. Examples are 0x8000 and 0xB7FF. A write to 0x8800 does not release it.
- R10: Reset clears the count to 0x0000, pauses counting, puts the toggle on the high byte and drives `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_tick | input | 1 | One-cycle strobe marking a CPU bus cycle |
| wr_en | input | 1 | CPU write strobe |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| irq_n | output | 1 | Interrupt request, active low, level held until acknowledged |
| count | output | 16 | Current count, for debug |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, a 16-bit count, the 0xF800 decode mask and enable on bit 4. Small counts are loaded, so an underflow from 0x0000 to 0xFFFF is reached within a few dozen ticks. Mirror addresses under both masks are exercised, along with a load that lands on a ticking cycle and an acknowledge after a control write.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;

    typedef enum logic {
        TGL_HI = 1'b0,
        TGL_LO = 1'b1
    } tgl_state_e;

    typedef enum logic {
        RUN_PAUSED = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

endpackage

// File: rtl/cyc_irq_decode.sv
module cyc_irq_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] REG_MASK  = 16'hF800,
    parameter logic [15:0] LOAD_ADDR = 16'hC800,
    parameter logic [15:0] CTRL_ADDR = 16'hD800,
    parameter logic [15:0] ACK_MASK  = 16'h8800,
    parameter logic [15:0] ACK_ADDR  = 16'h8000
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              load_wr,
    output logic              ctrl_wr,
    output logic              ack_wr
);
    localparam logic [ADDR_W-1:0] M_REG = ADDR_W'(REG_MASK);
    localparam logic [ADDR_W-1:0] M_ACK = ADDR_W'(ACK_MASK);

    always_comb begin
        load_wr = wr_en && ((addr & M_REG) == ADDR_W'(LOAD_ADDR));
        ctrl_wr = wr_en && ((addr & M_REG) == ADDR_W'(CTRL_ADDR));
        ack_wr  = wr_en && ((addr & M_ACK) == ADDR_W'(ACK_ADDR));
    end
endmodule

// File: rtl/cyc_irq_toggle.sv
module cyc_irq_toggle
    import cyc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_wr,
    input  logic ctrl_wr,
    output logic ld_hi,
    output logic ld_lo
);
    tgl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TGL_HI;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ld_hi   = 1'b0;
        ld_lo   = 1'b0;
        unique case (state_q)
            TGL_HI: begin
                ld_hi = load_wr;
                if (load_wr) state_d = TGL_LO;
            end
            TGL_LO: begin
                ld_lo = load_wr;
                if (load_wr) state_d = TGL_HI;
            end
            default: state_d = TGL_HI;
        endcase
        if (ctrl_wr) state_d = TGL_HI;
    end

    AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> state_q == TGL_HI);  // R4
    AST_TOGGLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi |=> state_q == TGL_LO);  // R2
endmodule

// File: rtl/cyc_irq_counter.sv
module cyc_irq_counter
    import cyc_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                ld_hi,
    input  logic                ld_lo,
    input  logic                ctrl_wr,
    input  logic                ctrl_en,
    input  logic                ack,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] cnt,
    output logic                irq
);
    localparam int CNT_W = 2 * DATA_W;

    run_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              irq_q, irq_d;
    logic              loading;
    logic              underflow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RUN_PAUSED;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            irq_q   <= irq_d;
        end
    end

    always_comb begin
        loading   = ld_hi || ld_lo;
        underflow = 1'b0;
        state_d   = state_q;
        cnt_d     = cnt_q;
        unique case (state_q)
            RUN_PAUSED: begin
                cnt_d = cnt_q;
            end
            RUN_ACTIVE: begin
                if (tick && !loading) begin
                    cnt_d     = cnt_q - 1'b1;
                    underflow = (cnt_q == '0);
                    if (underflow) state_d = RUN_PAUSED;
                end
            end
            default: state_d = RUN_PAUSED;
        endcase
        if (ld_hi) cnt_d = {wdata, cnt_q[DATA_W-1:0]};
        if (ld_lo) cnt_d = {cnt_q[CNT_W-1:DATA_W], wdata};
        if (ctrl_wr) state_d = ctrl_en ? RUN_ACTIVE : RUN_PAUSED;
        irq_d = underflow ? 1'b1 : (ack ? 1'b0 : irq_q);
    end

    assign cnt = cnt_q;
    assign irq = irq_q;

    AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi |=> cnt_q[CNT_W-1:DATA_W] == $past(wdata));  // R3
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_PAUSED && !loading) |=> $stable(cnt_q));  // R5
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_ACTIVE && tick && !loading && cnt_q != '0)
        |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));  // R6
    AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_ACTIVE && tick && !loading && cnt_q == '0 && !ctrl_wr)
        |=> (state_q == RUN_PAUSED && irq_q && cnt_q == '1));  // R7
    AST_CTRL_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && ctrl_wr && !ack) |=> irq_q);  // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !underflow) |=> !irq_q);  // R9
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          EN_BIT    = 4,
    parameter logic [15:0] REG_MASK  = 16'hF800,
    parameter logic [15:0] LOAD_ADDR = 16'hC800,
    parameter logic [15:0] CTRL_ADDR = 16'hD800,
    parameter logic [15:0] ACK_MASK  = 16'h8800,
    parameter logic [15:0] ACK_ADDR  = 16'h8000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_tick,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic                irq_n,
    output logic [2*DATA_W-1:0] count
);
    logic load_wr, ctrl_wr, ack_wr;
    logic ld_hi, ld_lo;
    logic irq;

    cyc_irq_decode #(
        .ADDR_W   (ADDR_W),
        .REG_MASK (REG_MASK),
        .LOAD_ADDR(LOAD_ADDR),
        .CTRL_ADDR(CTRL_ADDR),
        .ACK_MASK (ACK_MASK),
        .ACK_ADDR (ACK_ADDR)
    ) u_decode (
        .wr_en  (wr_en),
        .addr   (addr),
        .load_wr(load_wr),
        .ctrl_wr(ctrl_wr),
        .ack_wr (ack_wr)
    );

    cyc_irq_toggle u_toggle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_wr(load_wr),
        .ctrl_wr(ctrl_wr),
        .ld_hi  (ld_hi),
        .ld_lo  (ld_lo)
    );

    cyc_irq_counter #(
        .DATA_W(DATA_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (cpu_tick),
        .ld_hi  (ld_hi),
        .ld_lo  (ld_lo),
        .ctrl_wr(ctrl_wr),
        .ctrl_en(wdata[EN_BIT]),
        .ack    (ack_wr),
        .wdata  (wdata),
        .cnt    (count),
        .irq    (irq)
    );

    assign irq_n = !irq;
endmodule

// File: tb/cyc_irq_timer_test.sv
`timescale 1ns/1ps
module cyc_irq_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        irq_n;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cyc_irq_timer uut (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .irq_n(irq_n), .count(count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        cpu_tick = 1'b1;
        repeat (n) @(negedge clk);
        cpu_tick = 1'b0;
    endtask

    task automatic load16(input logic [15:0] v);
        wr(16'hD800, 8'h00);
        wr(16'hC800, v[15:8]);
        wr(16'hC800, v[7:0]);
    endtask

    task automatic t_reset;
        chk("R10 count after reset", count, 16'h0000);
        chk("R10 irq_n after reset", irq_n, 1'b1);
    endtask

    task automatic t_load_order;
        wr(16'hC800, 8'h12);
        chk("R2 high byte first", count, 16'h1200);
        wr(16'hC800, 8'h34);
        chk("R2 low byte second", count, 16'h1234);
        wr(16'hCFFF, 8'hAB);
        wr(16'hC800, 8'hCD);
        chk("R1 mirror of load register", count, 16'hABCD);
        wr(16'hE800, 8'hFF);
        chk("R1 unrelated register leaves count", count, 16'hABCD);
        chk("R1 unrelated register leaves irq", irq_n, 1'b1);
    endtask

    task automatic t_toggle_reset;
        wr(16'hC800, 8'h55);
        chk("R4 first byte lands high", count, 16'h55CD);
        wr(16'hD800, 8'h00);
        wr(16'hC800, 8'h66);
        chk("R4 control write resets toggle", count, 16'h66CD);
    endtask

    task automatic t_pause_and_run;
        ticks(5);
        chk("R5 paused count holds under ticks", count, 16'h66CD);
        load16(16'h0010);
        wr(16'hD800, 8'hEF);
        ticks(4);
        chk("R5 bit4 clear pauses", count, 16'h0010);
        wr(16'hD800, 8'h10);
        chk("R6 no tick no change", count, 16'h0010);
        ticks(5);
        chk("R6 five ticks", count, 16'h000B);
        repeat (3) @(negedge clk);
        chk("R6 strobe low holds", count, 16'h000B);
    endtask

    task automatic t_underflow;
        ticks(11);
        chk("R7 reaches zero", count, 16'h0000);
        chk("R7 no irq at zero", irq_n, 1'b1);
        ticks(1);
        chk("R7 wraps to FFFF", count, 16'hFFFF);
        chk("R7 irq asserted", irq_n, 1'b0);
        ticks(3);
        chk("R7 self-paused", count, 16'hFFFF);
    endtask

    task automatic t_ack;
        wr(16'hD800, 8'h00);
        chk("R8 control write keeps irq", irq_n, 1'b0);
        wr(16'h8800, 8'h00);
        chk("R9 0x8800 does not ack", irq_n, 1'b0);
        wr(16'h8000, 8'h00);
        chk("R9 ack releases irq", irq_n, 1'b1);
        load16(16'h0001);
        wr(16'hD800, 8'h10);
        ticks(2);
        chk("R9 second irq", irq_n, 1'b0);
        wr(16'hB7FF, 8'h00);
        chk("R9 mirror ack releases irq", irq_n, 1'b1);
    endtask

    task automatic t_load_priority;
        load16(16'h2000);
        wr(16'hD800, 8'h10);
        @(negedge clk);
        cpu_tick = 1'b1; wr_en = 1'b1; addr = 16'hC800; wdata = 8'h30;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 load beats decrement", count, 16'h3000);
        @(negedge clk);
        cpu_tick = 1'b0;
        chk("R3 decrement resumes", count, 16'h2FFF);
    endtask

    task automatic t_reset_mid;
        load16(16'h0000);
        wr(16'hD800, 8'h10);
        ticks(1);
        wr(16'hC800, 8'h44);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset clears count", count, 16'h0000);
        chk("R10 reset clears irq", irq_n, 1'b1);
        ticks(3);
        chk("R10 reset pauses", count, 16'h0000);
        wr(16'hC800, 8'h77);
        chk("R10 reset toggle high", count, 16'h7700);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_order();
        t_toggle_reset();
        t_pause_and_run();
        t_underflow();
        t_ack();
        t_load_priority();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule